// File: doc/BRIEF.md
# Predicated Vector Element Write Sequencer

This block walks through the elements of one vector operation and turns each incoming element result into a single write on the port of a 128-entry register file of 64-bit registers. Elements are packed into registers by a programmable element width of 8, 16, 32 or 64 bits. For every element the block works out the target register and the byte lanes it covers, places the result at those lanes, and drives the byte-lane write enables from that element's predicate bit. A masked-off or narrow element therefore never needs the old register contents, because lanes outside the element, or the whole element when its predicate bit is clear, are simply left unwritten.

A controller pulses `start` with the vector length, element width code, base register and predicate mask. Results then arrive one per element on a valid/ready stream, in element order. Each accepted result produces one registered write in the next cycle, and `done` marks the end of the operation. A vector length of zero, or a vector that would run past the last register, completes at once without writing anything.

Top module: `vec_elem_writer`

## Requirements
- R1: A start with vector length 0 raises `done` in the cycle after the start edge, with `wr_en` low and `err` low, whatever the width, base and mask.
- R2: Elements are handled in ascending order from 0 to VL-1. Each accepted result (`res_valid` and `res_ready` high at an edge) gives exactly one cycle of `wr_en` in the following cycle, and `done` is high in the same cycle as the last element's write.
- R3: The width code is 2'b00 for 64-bit, 2'b01 for 32-bit, 2'b10 for 16-bit and 2'b11 for 8-bit elements. With B the element size in bytes, element i writes register `base + (i*B)/8`.
- R4: With its predicate bit (bit i of the mask) set, element i enables exactly B consecutive byte lanes, starting at lane `(i*B)%8`. Lane k covers bits 8k+7 down to 8k.
- R5: An element whose predicate bit is 0 still takes its cycle, and `wr_en` pulses for it, but all `wr_be` bits are 0.
- R6: `wr_data` holds the low 8*B bits of the element's result, shifted up by 8 times the lane offset. All other bits are zero.
- R7: If `base + (VL*B-1)/8` is greater than 127 (and VL is not 0), `err` and `done` are high in the cycle after the start edge. No write happens and `res_ready` stays low.
- R8: `res_ready` is high only while a vector is in progress. A cycle without `res_valid` produces no write. Whenever `wr_en` is low, `wr_be` is 0.
- R9: A `start` pulse that arrives while a vector is in progress is ignored. The running vector finishes with its own settings.
- R10: After reset, `wr_en`, `wr_be`, `done`, `err` and `res_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a vector operation (taken only when idle) |
| vec_len | input | 7 | Number of elements, 0 to 64 |
| ew_code | input | 2 | Element width code (00=64, 01=32, 10=16, 11=8 bits) |
| base_reg | input | 7 | First target register |
| pred_mask | input | 64 | Predicate, bit i for element i |
| res_valid | input | 1 | Element result available |
| res_data | input | 64 | Element result, right-aligned |
| res_ready | output | 1 | Block accepts a result this cycle |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 7 | Register number written |
| wr_be | output | 8 | Byte-lane write enables |
| wr_data | output | 64 | Lane-aligned write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Range-overflow flag, pulses together with done |

## Verification
The element counter, the latched width and the latched base are all internal state. Each of them shows up on the very next write after it goes wrong. A miscounted element index gives the wrong register or lane offset at once, and it also moves the `done` pulse early or late relative to the last write. A corrupted width shows in the count of enabled lanes and in how much result data reaches `wr_data`. A stuck controller state shows up as `res_ready` being high while `done` is high, or low while a vector still has elements left.

// File: rtl/vew_pkg.sv
package vew_pkg;
  typedef enum logic [1:0] {
    EW64 = 2'b00,
    EW32 = 2'b01,
    EW16 = 2'b10,
    EW8  = 2'b11
  } ew_e;

  localparam int REG_BYTES = 8;
  localparam int REG_BITS  = REG_BYTES * 8;

  // log2 of element size in bytes
  function automatic logic [1:0] ew_shift(input logic [1:0] code);
    return 2'd3 - code;
  endfunction
endpackage

// File: rtl/vew_ctrl.sv
module vew_ctrl
  import vew_pkg::*;
#(
  parameter int MAX_VL  = 64,
  parameter int REG_CNT = 128,
  localparam int VL_W   = $clog2(MAX_VL + 1),
  localparam int EI_W   = $clog2(MAX_VL),
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VL_W-1:0]   vec_len,
  input  logic [1:0]        ew_code,
  input  logic [IDX_W-1:0]  base_reg,
  input  logic [MAX_VL-1:0] pred_mask,
  input  logic              res_valid,
  output logic              res_ready,
  output logic              fire,
  output logic              last,
  output logic [EI_W-1:0]   elem,
  output logic              elem_pred,
  output logic [1:0]        ew_q,
  output logic [IDX_W-1:0]  base_q,
  output logic              take_start,
  output logic              quick_done,
  output logic              quick_err
);
  localparam int SP_W = IDX_W + VL_W + 3;

  typedef enum logic {S_IDLE, S_RUN} st_e;
  st_e                st;
  logic [VL_W-1:0]    vl_q;
  logic [MAX_VL-1:0]  pred_q;
  logic [SP_W-1:0]    span_bytes;
  logic [SP_W-1:0]    last_reg;
  logic               ovf;

  always_comb begin
    span_bytes = SP_W'(vec_len) << ew_shift(ew_code);
    last_reg   = SP_W'(base_reg) + ((span_bytes - SP_W'(1)) >> 3);
    ovf        = last_reg > SP_W'(REG_CNT - 1);
  end

  assign take_start = start && (st == S_IDLE);
  assign quick_done = take_start && ((vec_len == '0) || ovf);
  assign quick_err  = take_start && (vec_len != '0) && ovf;
  assign res_ready  = (st == S_RUN);
  assign fire       = res_ready && res_valid;
  assign last       = (elem == EI_W'(vl_q - VL_W'(1)));
  assign elem_pred  = pred_q[elem];

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      vl_q   <= '0;
      pred_q <= '0;
      ew_q   <= '0;
      base_q <= '0;
      elem   <= '0;
    end else begin
      if (take_start) begin
        vl_q   <= vec_len;
        pred_q <= pred_mask;
        ew_q   <= ew_code;
        base_q <= base_reg;
        elem   <= '0;
        if (!quick_done) st <= S_RUN;
      end else if (fire) begin
        if (last) st <= S_IDLE;
        else      elem <= elem + EI_W'(1);
      end
    end
  end

  // R2
  elem_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !last) |=> (elem == $past(elem) + EI_W'(1)));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN && !fire) |=> ($stable(vl_q) && $stable(ew_q) && $stable(base_q)));
endmodule

// File: rtl/vew_lane.sv
module vew_lane
  import vew_pkg::*;
#(
  parameter int MAX_VL  = 64,
  parameter int REG_CNT = 128,
  localparam int EI_W   = $clog2(MAX_VL),
  localparam int IDX_W  = $clog2(REG_CNT),
  localparam int BE_W   = REG_BYTES,
  localparam int LANE_W = $clog2(REG_BYTES)
) (
  input  logic [EI_W-1:0]     elem,
  input  logic [1:0]          ew_code,
  input  logic [IDX_W-1:0]    base_reg,
  input  logic                pbit,
  input  logic [REG_BITS-1:0] res_data,
  output logic [IDX_W-1:0]    idx,
  output logic [BE_W-1:0]     be,
  output logic [REG_BITS-1:0] data
);
  localparam int POS_W = EI_W + LANE_W;

  logic [POS_W-1:0]    pos;
  logic [LANE_W-1:0]   lane;
  logic [LANE_W:0]     nbytes;
  logic [BE_W-1:0]     keep;
  logic [REG_BITS-1:0] masked;

  assign pos    = POS_W'(elem) << ew_shift(ew_code);
  assign lane   = pos[LANE_W-1:0];
  assign nbytes = (LANE_W+1)'(1) << ew_shift(ew_code);
  assign idx    = base_reg + IDX_W'(pos >> LANE_W);

  for (genvar b = 0; b < BE_W; b++) begin : g_byte
    assign keep[b]          = (b < int'(nbytes));
    assign masked[8*b +: 8] = keep[b] ? res_data[8*b +: 8] : 8'h00;
  end

  assign be   = pbit ? (keep << lane) : '0;
  assign data = masked << {lane, 3'b000};
endmodule

// File: rtl/vec_elem_writer.sv
module vec_elem_writer
  import vew_pkg::*;
#(
  parameter int MAX_VL  = 64,
  parameter int REG_CNT = 128,
  localparam int VL_W   = $clog2(MAX_VL + 1),
  localparam int EI_W   = $clog2(MAX_VL),
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [VL_W-1:0]      vec_len,
  input  logic [1:0]           ew_code,
  input  logic [IDX_W-1:0]     base_reg,
  input  logic [MAX_VL-1:0]    pred_mask,
  input  logic                 res_valid,
  input  logic [REG_BITS-1:0]  res_data,
  output logic                 res_ready,
  output logic                 wr_en,
  output logic [IDX_W-1:0]     wr_idx,
  output logic [REG_BYTES-1:0] wr_be,
  output logic [REG_BITS-1:0]  wr_data,
  output logic                 done,
  output logic                 err
);
  logic              fire, last, elem_pred, take_start, quick_done, quick_err;
  logic [EI_W-1:0]   elem;
  logic [1:0]        ew_q;
  logic [IDX_W-1:0]  base_q;
  logic [IDX_W-1:0]     n_idx;
  logic [REG_BYTES-1:0] n_be;
  logic [REG_BITS-1:0]  n_data;

  vew_ctrl #(.MAX_VL(MAX_VL), .REG_CNT(REG_CNT)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .vec_len(vec_len),
    .ew_code(ew_code), .base_reg(base_reg), .pred_mask(pred_mask),
    .res_valid(res_valid), .res_ready(res_ready), .fire(fire), .last(last),
    .elem(elem), .elem_pred(elem_pred), .ew_q(ew_q), .base_q(base_q),
    .take_start(take_start), .quick_done(quick_done), .quick_err(quick_err)
  );

  vew_lane #(.MAX_VL(MAX_VL), .REG_CNT(REG_CNT)) u_lane (
    .elem(elem), .ew_code(ew_q), .base_reg(base_q), .pbit(elem_pred),
    .res_data(res_data), .idx(n_idx), .be(n_be), .data(n_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_be   <= '0;
      wr_data <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      wr_en <= fire;
      done  <= quick_done || (fire && last);
      err   <= quick_err;
      if (fire) begin
        wr_idx  <= n_idx;
        wr_be   <= n_be;
        wr_data <= n_data;
      end else begin
        wr_be   <= '0;
      end
    end
  end

  // R1
  empty_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (take_start && vec_len == '0) |=> (done && !wr_en && !err));

  // R7
  ovf_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && !wr_en && !res_ready));

  // R4
  lane_count_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($countones(wr_be) == 0 ||
               $countones(wr_be) == (1 << ew_shift(ew_q))));

  // R8
  ready_vs_done_chk: assert property (@(posedge clk) disable iff (rst)
    res_ready |-> !done);

  // R8
  idle_be_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> (wr_be == '0));
endmodule

// File: tb/tb_vec_elem_writer.sv
`timescale 1ns/1ps
module tb_vec_elem_writer;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [6:0]  vec_len;
  logic [1:0]  ew_code;
  logic [6:0]  base_reg;
  logic [63:0] pred_mask;
  logic        res_valid;
  logic [63:0] res_data;
  logic        res_ready, wr_en, done, err;
  logic [6:0]  wr_idx;
  logic [7:0]  wr_be;
  logic [63:0] wr_data;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  vec_elem_writer dut (
    .clk(clk), .rst(rst), .start(start), .vec_len(vec_len), .ew_code(ew_code),
    .base_reg(base_reg), .pred_mask(pred_mask), .res_valid(res_valid),
    .res_data(res_data), .res_ready(res_ready), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_be(wr_be), .wr_data(wr_data), .done(done), .err(err)
  );

  // {vec_len[6:0], ew_code[1:0], base_reg[6:0], pred_mask[63:0]}
  localparam logic [79:0] VEC [8] = '{
    {7'd5,  2'b00, 7'd10,  64'h0000_0000_0000_001B},
    {7'd8,  2'b11, 7'd0,   64'h0000_0000_0000_00A5},
    {7'd9,  2'b10, 7'd120, 64'h0000_0000_0000_01F6},
    {7'd7,  2'b01, 7'd124, 64'h0000_0000_0000_0055},
    {7'd3,  2'b00, 7'd126, 64'h0000_0000_0000_0007},
    {7'd0,  2'b00, 7'd127, 64'h0000_0000_0000_000F},
    {7'd64, 2'b11, 7'd20,  64'hF0F0_1234_8000_0001},
    {7'd64, 2'b11, 7'd121, 64'hFFFF_FFFF_FFFF_FFFF}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] elem_val(input int k);
    return 64'hFEDC_BA98_7654_3210 ^ (64'(k) * 64'h0101_0101_0101_0101);
  endfunction

  task automatic run_vec(input logic [6:0] vl, input logic [1:0] ew,
                         input logic [6:0] base, input logic [63:0] pm,
                         input bit stall);
    int nb, lastreg;
    nb = 8 >> ew;
    lastreg = int'(base) + ((int'(vl) * nb - 1) / 8);
    @(negedge clk);
    start = 1'b1; vec_len = vl; ew_code = ew; base_reg = base; pred_mask = pm;
    @(negedge clk);
    start = 1'b0;
    if (vl == 0) begin
      chk("R1 done", 64'(done), 64'd1);
      chk("R1 wr_en", 64'(wr_en), 64'd0);
      chk("R1 err", 64'(err), 64'd0);
    end else if (lastreg > 127) begin
      chk("R7 err", 64'(err), 64'd1);
      chk("R7 done", 64'(done), 64'd1);
      chk("R7 wr_en", 64'(wr_en), 64'd0);
      chk("R7 ready", 64'(res_ready), 64'd0);
      @(negedge clk);
      chk("R7 ready later", 64'(res_ready), 64'd0);
      chk("R7 no write later", 64'(wr_en), 64'd0);
    end else begin
      chk("R8 ready in run", 64'(res_ready), 64'd1);
      for (int k = 0; k < int'(vl); k++) begin
        int pos, lane;
        logic [63:0] msk, ebe, edata;
        if (stall && (k % 3 == 1)) begin
          res_valid = 1'b0;
          @(negedge clk);
          chk("R8 stall no write", 64'(wr_en), 64'd0);
          chk("R8 stall be", 64'(wr_be), 64'd0);
        end
        res_valid = 1'b1;
        res_data  = elem_val(k);
        @(negedge clk);
        pos   = k * nb;
        lane  = pos % 8;
        msk   = (nb == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * nb)) - 64'd1);
        ebe   = pm[k] ? (((64'd1 << nb) - 64'd1) << lane) : 64'd0;
        edata = (elem_val(k) & msk) << (8 * lane);
        chk("R2 wr_en", 64'(wr_en), 64'd1);
        chk("R3 idx", 64'(wr_idx), 64'(int'(base) + pos / 8));
        if (pm[k]) chk("R4 be", 64'(wr_be), ebe);
        else       chk("R5 be masked", 64'(wr_be), 64'd0);
        chk("R6 data", wr_data, edata);
        chk("R2 done timing", 64'(done), 64'(k == int'(vl) - 1));
      end
      res_valid = 1'b0;
      @(negedge clk);
      chk("R2 no extra write", 64'(wr_en), 64'd0);
      chk("R8 ready after end", 64'(res_ready), 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog R2 act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; vec_len = '0; ew_code = '0; base_reg = '0;
    pred_mask = '0; res_valid = 1'b0; res_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 wr_en", 64'(wr_en), 64'd0);
    chk("R10 wr_be", 64'(wr_be), 64'd0);
    chk("R10 done", 64'(done), 64'd0);
    chk("R10 err", 64'(err), 64'd0);
    chk("R10 ready", 64'(res_ready), 64'd0);

    for (int v = 0; v < 8; v++)
      run_vec(VEC[v][79:73], VEC[v][72:71], VEC[v][70:64], VEC[v][63:0], v == 2 || v == 6);

    // R9: start during a run is ignored
    @(negedge clk);
    start = 1'b1; vec_len = 7'd2; ew_code = 2'b00; base_reg = 7'd3; pred_mask = 64'h3;
    @(negedge clk);
    start = 1'b1; vec_len = 7'd5; ew_code = 2'b11; base_reg = 7'd40; pred_mask = 64'h0;
    res_valid = 1'b1; res_data = 64'h1111_2222_3333_4444;
    @(negedge clk);
    start = 1'b0;
    chk("R9 idx e0", 64'(wr_idx), 64'd3);
    chk("R9 be e0", 64'(wr_be), 64'hFF);
    res_data = 64'h5555_6666_7777_8888;
    @(negedge clk);
    chk("R9 idx e1", 64'(wr_idx), 64'd4);
    chk("R9 done", 64'(done), 64'd1);
    res_valid = 1'b0;
    @(negedge clk);
    chk("R9 idle after", 64'(res_ready), 64'd0);
    chk("R9 no write", 64'(wr_en), 64'd0);

    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule